// File: doc/BRIEF.md
# Dual-Mode Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory with a 128-byte internal array. It samples the bus clock (SCL), the bus data line (SDA) and a separate write-enable level input in the system clock domain. Each of the three passes through a two-flop synchronizer, and all edges are found on the synchronized values. The block detects start and stop conditions and decodes a device address byte. It then serves byte writes, page writes, addressed reads and sequential reads. SDA is open-drain: the block only ever pulls the line low, through an output-enable.

After reset the block is in a passive power-up mode and leaves the bus alone. The first falling SCL edge moves it into bidirectional mode, and it stays there for good. In bidirectional mode the separate clock input is used only as a level. While that level is low, incoming data bytes are refused and nothing is stored.

Top module: `tw_mem_slave`

## Requirements
- R1: `bidir_o` is 0 after reset, becomes 1 after the first falling edge of SCL, and then stays 1 until reset.
- R2: While `bidir_o` is 0, `sda_oe_o` stays 0, including through a start condition.
- R3: A start condition (SDA falls while SCL is high) seen in the middle of a byte drops that partial byte and restarts device address decoding. The dropped bits are never written to memory.
- R4: The device address byte is accepted when its bits [7:4] equal 1010. Bits [3:1] are ignored, and bit 0 selects read (1) or write (0). On acceptance the slave pulls SDA low during the ninth clock.
- R5: On a device address mismatch the slave does not acknowledge. It keeps SDA released for every following byte until the next start condition.
- R6: In a write, the byte after the device address sets the 7-bit word address. Each later data byte is acknowledged and stored at the current address while the write-enable level `vclk_i` is high.
- R7: A data byte received while `vclk_i` is low is not acknowledged (SDA stays high on the ninth clock) and does not change memory.
- R8: After each stored byte, the word address increments only in bits [2:0], so page writes wrap within an aligned 8-byte page.
- R9: A read starts at the current word address, which can be set by a write that carries only the word address followed by a repeated start. Bytes are sent MSB first, with a bit changing only while SCL is low.
- R10: During a read, a master acknowledge (SDA low on the ninth clock) makes the slave send the next byte. The address increments across the whole array and wraps from 127 to 0.
- R11: A master no-acknowledge (SDA high on the ninth clock) ends the read. The slave keeps SDA released on the clocks that follow.
- R12: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| vclk_i | input | 1 | Power-up clock input; write-enable level in bidirectional mode |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| bidir_o | output | 1 | 1 once the slave is in bidirectional mode |

## Verification
The hardest state to reach from the ports is a repeated start that lands in the middle of a data byte, after the word address has already been taken. The bench gets there by bit-banging a write with a word address, shifting in four data bits with SCL left high, and then raising and dropping SDA to form a new start. It follows with a read command. A correct slave must send the old content of that address, because the partial byte was dropped and the word address byte set the pointer. The bench also models the wired-AND bus, so the slave's own pull-down shows up on the line it samples. A monitor records every change of the output-enable against the SCL level.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tw_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_WADDR,
    K_WDATA
  } tw_kind_e;

  localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= rst_val_i;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tw_mem.sv
module tw_mem #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else if (we_i) begin
      cell_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = cell_q[addr_i];
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
  import tw_pkg::*;
#(
  parameter int AW      = 7,
  parameter int PAGE_AW = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic vclk_i,
  output logic sda_oe_o,
  output logic bidir_o
);
  localparam int DW = 8;

  logic [2:0] sync_q;
  logic scl_q, sda_q, vclk_q, scl_d, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;

  tw_sync #(.W(3), .STAGES(2)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({scl_i, sda_i, vclk_i}),
    .rst_val_i(3'b110),
    .q_o      (sync_q)
  );
  assign {scl_q, sda_q, vclk_q} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

  tw_state_e     state_q;
  tw_kind_e      kind_q;
  logic [2:0]    cnt_q;
  logic [DW-1:0] shreg_q;
  logic          rw_q, oe_q, bidir_q, full_q, nack_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] mem_rdata;
  logic          mem_we;

  assign mem_we = (state_q == ST_RX) && !start_det && !stop_det && scl_fall
                  && full_q && (kind_q == K_WDATA) && vclk_q;

  tw_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .addr_i (addr_q),
    .wdata_i(shreg_q),
    .rdata_o(mem_rdata)
  );

  // mode latch: first SCL fall leaves power-up mode for good
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bidir_q <= 1'b0;
    else if (scl_fall) bidir_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      shreg_q <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      full_q  <= 1'b0;
      nack_q  <= 1'b0;
      addr_q  <= '0;
    end else if (start_det) begin
      state_q <= ST_RX;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_q <= {shreg_q[DW-2:0], sda_q};
            cnt_q   <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) full_q <= 1'b1;
          end else if (scl_fall && full_q) begin
            full_q <= 1'b0;
            unique case (kind_q)
              K_DEV: begin
                if (shreg_q[7:4] == DEV_TAG) begin
                  rw_q    <= shreg_q[0];
                  oe_q    <= 1'b1;
                  state_q <= ST_RX_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              K_WADDR: begin
                addr_q  <= shreg_q[AW-1:0];
                oe_q    <= 1'b1;
                state_q <= ST_RX_ACK;
              end
              default: begin
                if (vclk_q) begin
                  oe_q   <= 1'b1;
                  addr_q <= {addr_q[AW-1:PAGE_AW], addr_q[PAGE_AW-1:0] + PAGE_AW'(1)};
                end
                state_q <= ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (kind_q == K_DEV && rw_q) begin
              state_q <= ST_TX;
              shreg_q <= mem_rdata;
              oe_q    <= ~mem_rdata[DW-1];
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_RX;
              kind_q  <= (kind_q == K_DEV) ? K_WADDR : K_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              oe_q    <= 1'b0;
              addr_q  <= addr_q + AW'(1);
              state_q <= ST_TX_ACK;
            end else begin
              shreg_q <= {shreg_q[DW-2:0], 1'b0};
              oe_q    <= ~shreg_q[DW-2];
              cnt_q   <= cnt_q + 3'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) nack_q <= sda_q;
          else if (scl_fall) begin
            if (!nack_q) begin
              state_q <= ST_TX;
              cnt_q   <= '0;
              shreg_q <= mem_rdata;
              oe_q    <= ~mem_rdata[DW-1];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q & bidir_q;
  assign bidir_o  = bidir_q;

  a_r1_mode_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bidir_q |=> bidir_q);

  a_r2_quiet_power_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bidir_o |-> !sda_oe_o);

  a_r12_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_q);

  a_r4_ack_needs_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX_ACK && kind_q == K_DEV && oe_q) |-> shreg_q[7:4] == DEV_TAG);

  a_r8_page_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> addr_q[AW-1:PAGE_AW] == $past(addr_q[AW-1:PAGE_AW]));
endmodule

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, vclk = 1'b1;
  logic sda_oe, bidir;
  logic sda_line;
  int n_chk = 0, n_fail = 0, oe_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  tw_mem_slave u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (m_scl),
    .sda_i   (sda_line),
    .vclk_i  (vclk),
    .sda_oe_o(sda_oe),
    .bidir_o (bidir)
  );

  // R12 monitor
  always @(sda_oe) if (rst_n && m_scl) oe_bad++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_scl = 1'b0; wt(H/2); m_sda = 1'b1; wt(H/2);
    m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; wt(H/2); m_sda = 1'b0; wt(H/2);
    m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    m_scl = 1'b0; wt(H/2); m_sda = b; wt(H/2);
    m_scl = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_scl = 1'b0; wt(H/2); m_sda = 1'b1; wt(H/2);
    m_scl = 1'b1; wt(H/2); ack = ~sda_line; wt(H/2);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_scl = 1'b0; wt(H/2); m_sda = 1'b1; wt(H/2);
    for (int i = 7; i >= 0; i--) begin
      if (i != 7) begin m_scl = 1'b0; wt(H); end
      m_scl = 1'b1; wt(H/2); b[i] = sda_line; wt(H/2);
    end
    m_scl = 1'b0; wt(H/2); m_sda = ~give_ack; wt(H/2);
    m_scl = 1'b1; wt(H);
  endtask

  task automatic set_ptr(input logic [6:0] a);
    logic ack;
    bus_start();
    send_byte(8'hA0, ack); chk("R4 dev ack", ack, 1);
    send_byte({1'b0, a}, ack); chk("R6 waddr ack", ack, 1);
  endtask

  task automatic write_bytes(input logic [6:0] a, input logic [7:0] d [], input int exp_ack);
    logic ack;
    set_ptr(a);
    foreach (d[i]) begin
      send_byte(d[i], ack);
      chk("R6/R7 data ack", ack, exp_ack);
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic [6:0] a, input logic [7:0] exp [], input string req);
    logic ack;
    logic [7:0] b;
    set_ptr(a);
    bus_start();
    send_byte(8'hA5, ack); chk("R4 read cmd ack (bits 3:1 ignored)", ack, 1);
    foreach (exp[i]) begin
      recv_byte(i != exp.size() - 1, b);
      chk(req, b, exp[i]);
    end
    bus_stop();
  endtask

  task automatic t_reset_mode();
    chk("R1 reset mode", bidir, 0);
    chk("R2 reset oe", sda_oe, 0);
    m_sda = 1'b0; wt(H);
    chk("R2 start in power-up mode", sda_oe, 0);
    chk("R1 still power-up", bidir, 0);
    m_sda = 1'b1; wt(H);
    m_scl = 1'b0; wt(H); m_scl = 1'b1; wt(H);
    chk("R1 bidir after SCL fall", bidir, 1);
    bus_stop();
    chk("R1 bidir sticky", bidir, 1);
  endtask

  task automatic t_byte_write_read();
    write_bytes(7'h12, '{8'h5A}, 1);
    read_seq(7'h12, '{8'h5A}, "R9 byte read");
  endtask

  task automatic t_page_wrap();
    write_bytes(7'h4E, '{8'h11, 8'h22, 8'h33, 8'h44}, 1);
    read_seq(7'h48, '{8'h33, 8'h44}, "R8 wrapped bytes");
    read_seq(7'h4E, '{8'h11, 8'h22}, "R8 page tail");
    read_seq(7'h50, '{8'h00}, "R8 next page untouched");
  endtask

  task automatic t_seq_wrap();
    write_bytes(7'h7F, '{8'hC3}, 1);
    write_bytes(7'h00, '{8'h3C}, 1);
    read_seq(7'h7F, '{8'hC3, 8'h3C}, "R10 seq read wraps 127->0");
  endtask

  task automatic t_vclk_low();
    vclk = 1'b0; wt(H);
    write_bytes(7'h30, '{8'h55}, 0);
    vclk = 1'b1; wt(H);
    read_seq(7'h30, '{8'h00}, "R7 no store with vclk low");
  endtask

  task automatic t_mismatch();
    logic ack;
    bus_start();
    send_byte(8'h50, ack); chk("R5 mismatch nack", ack, 0);
    send_byte(8'hA0, ack); chk("R5 released until start", ack, 0);
    bus_stop();
  endtask

  task automatic t_restart_mid_byte();
    logic ack;
    logic [7:0] b;
    set_ptr(7'h20);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'hAB, ack); chk("R3 decode restarted", ack, 1);
    recv_byte(1'b0, b);
    chk("R3 partial byte dropped", b, 8'h00);
    bus_stop();
  endtask

  task automatic t_master_nack();
    logic ack;
    logic [7:0] b;
    int low = 0;
    set_ptr(7'h12);
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, b);
    chk("R9 read value", b, 8'h5A);
    m_scl = 1'b0; wt(H/2); m_sda = 1'b1; wt(H/2);
    for (int i = 0; i < 8; i++) begin
      m_scl = 1'b1; wt(H/2);
      if (!sda_line) low++;
      wt(H/2); m_scl = 1'b0; wt(H);
    end
    chk("R11 released after nack", low, 0);
    bus_stop();
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset_mode();
    t_byte_write_read();
    t_page_wrap();
    t_seq_wrap();
    t_vclk_low();
    t_mismatch();
    t_restart_mid_byte();
    t_master_nack();
    chk("R12 oe changes only with SCL low", oe_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule